// File: doc/BRIEF.md
# Host Port Dual Address Registers

This block keeps the address pointers that an external host uses to reach on-chip memory through a 16-bit host port. Each host access carries a 2-bit control field that names its target. Value 00 is the control register, 10 is an address register, 01 is a data access that advances the pointer afterwards, and 11 is a data access that leaves the pointer alone. A halfword flag marks whether an access carries the first or the second halfword of a 32-bit transfer.

There are two 32-bit pointers, one for memory reads and one for memory writes. With the mode bit clear they act as one shared pointer. With it set they are independent, and a host-programmed select bit decides which of them host address accesses reach. The internal transfer engine does not look at the select bit. It always takes the read pointer for memory reads and the write pointer for memory writes, and the block drives both pointers out continuously for that purpose. The data path, the FIFOs, interrupts and strobe timing belong to other blocks.

Top module: `hpi_addr_regs`

## Requirements
- R1: After reset, both pointers are zero. The mode bit (control bit 0) is zero and the select bit (control bit 1) is zero.
- R2: A write with control field 00 and halfword flag 0 loads the mode bit from data bit 0 and the select bit from data bit 1. A read with field 00 and flag 0 returns {14'b0, select, mode} on the same cycle. A read with field 00 and flag 1 returns zero.
- R3: An address-register write (field 10) with halfword flag 0 only stages the low 16 bits and changes neither pointer. The following write with flag 1 supplies bits 31:16 and updates the target register in the next cycle.
- R4: In single mode (mode bit 0), a completed address write loads both pointers with the same value, and an address read returns the read pointer. The select bit has no effect in this mode.
- R5: In dual mode with select 1, host address writes and reads reach only the read pointer, and the write pointer is unchanged.
- R6: In dual mode with select 0, host address writes and reads reach only the write pointer, and the read pointer is unchanged.
- R7: In dual mode, a read with field 01 and flag 1 presents the current read pointer on the memory read address during the access. In the next cycle the read pointer is 4 higher (modulo 2^32), and the write pointer is unchanged.
- R8: In dual mode, a write with field 01 and flag 1 presents the current write pointer on the memory write address during the access. In the next cycle the write pointer is 4 higher (modulo 2^32), and the read pointer is unchanged.
- R9: A data access with field 11 changes neither pointer, whatever its direction or halfword.
- R10: In single mode, an autoincrementing access with flag 1 advances both pointers by 4, whatever its direction.
- R11: The memory read address always equals the read pointer and the memory write address always equals the write pointer, whatever value the select bit holds.
- R12: An autoincrementing access with halfword flag 0 does not advance any pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | One-cycle strobe marking a host access |
| host_ctl | input | 2 | Access target: 00 control, 01 data with increment, 10 address, 11 data |
| host_rnw | input | 1 | 1 for a host read, 0 for a host write |
| host_hw | input | 1 | Halfword flag: 0 first (low) halfword, 1 second (high) halfword |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for control and address reads, zero otherwise |
| mem_rd_addr | output | 32 | Read pointer as seen by the transfer engine |
| mem_wr_addr | output | 32 | Write pointer as seen by the transfer engine |

## Verification
The assertions assume that `host_valid` is a single-cycle strobe, that `host_ctl`, `host_rnw`, `host_hw` and `host_wdata` are stable while it is high, and that each address write sends its low halfword before its high halfword. The stimulus drives every access as one valid cycle set up on the falling edge, and it always sends address halfwords in low-then-high order. It repeats the same sequence of control, address, autoincrement and plain data accesses under all four combinations of mode and select. It also includes pointer values just below the top of the address space, so that the increment wraps.

// File: rtl/hpi_addr_regs.sv
module hpi_addr_regs #(
  parameter int STEP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_valid,
  input  logic [1:0]  host_ctl,
  input  logic        host_rnw,
  input  logic        host_hw,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic [31:0] mem_rd_addr,
  output logic [31:0] mem_wr_addr
);
  localparam logic [31:0] INC = 32'(STEP);

  logic [31:0] rd_q, wr_q;
  logic [15:0] stage_q;
  logic        dual_q, sel_q;

  wire wr_acc = host_valid & ~host_rnw;
  wire ctl_wr = wr_acc & (host_ctl == 2'b00) & ~host_hw;
  wire adr_lo = wr_acc & (host_ctl == 2'b10) & ~host_hw;
  wire adr_hi = wr_acc & (host_ctl == 2'b10) & host_hw;
  wire [31:0] adr_new = {host_wdata, stage_q};
  wire hit_rd = adr_hi & (~dual_q | sel_q);
  wire hit_wr = adr_hi & (~dual_q | ~sel_q);
  wire inc_go = host_valid & (host_ctl == 2'b01) & host_hw;
  wire inc_rd = inc_go & (host_rnw | ~dual_q);
  wire inc_wr = inc_go & (~host_rnw | ~dual_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      stage_q <= '0;
      dual_q  <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      if (ctl_wr) begin
        dual_q <= host_wdata[0];
        sel_q  <= host_wdata[1];
      end
      if (adr_lo) stage_q <= host_wdata;
      if (hit_rd)      rd_q <= adr_new;
      else if (inc_rd) rd_q <= rd_q + INC;
      if (hit_wr)      wr_q <= adr_new;
      else if (inc_wr) wr_q <= wr_q + INC;
    end
  end

  wire [31:0] host_view = (dual_q & ~sel_q) ? wr_q : rd_q;

  always_comb begin
    host_rdata = '0;
    if (host_ctl == 2'b00 && !host_hw)
      host_rdata = {14'b0, sel_q, dual_q};
    else if (host_ctl == 2'b10)
      host_rdata = host_hw ? host_view[31:16] : host_view[15:0];
  end

  assign mem_rd_addr = rd_q;
  assign mem_wr_addr = wr_q;

  // R3
  lo_half_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adr_lo |=> $stable(mem_rd_addr) && $stable(mem_wr_addr));

  // R4
  single_load_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_hi && !dual_q) |=> mem_rd_addr == mem_wr_addr);

  // R5
  sel_rd_spares_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_hi && dual_q && sel_q) |=> $stable(mem_wr_addr));

  // R6
  sel_wr_spares_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adr_hi && dual_q && !sel_q) |=> $stable(mem_rd_addr));

  // R7
  auto_rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_go && host_rnw && dual_q) |=>
      mem_rd_addr == $past(mem_rd_addr) + INC && $stable(mem_wr_addr));

  // R8
  auto_wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_go && !host_rnw && dual_q) |=>
      mem_wr_addr == $past(mem_wr_addr) + INC && $stable(mem_rd_addr));

  // R9
  plain_data_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ctl == 2'b11) |=> $stable(mem_rd_addr) && $stable(mem_wr_addr));

  // R12
  first_half_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && host_ctl == 2'b01 && !host_hw) |=>
      $stable(mem_rd_addr) && $stable(mem_wr_addr));
endmodule

// File: tb/hpi_addr_regs_test.sv
module hpi_addr_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic [1:0]  host_ctl = 2'b00;
  logic        host_rnw = 1'b1;
  logic        host_hw = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [31:0] mem_rd_addr, mem_wr_addr;

  int vectors = 0;
  int errors = 0;

  logic [31:0] m_rd = '0, m_wr = '0;
  logic [15:0] m_stage = '0;
  logic        m_dual = 1'b0, m_sel = 1'b0;

  always #5 clk = ~clk;

  hpi_addr_regs uut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ctl(host_ctl),
    .host_rnw(host_rnw), .host_hw(host_hw), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mem_rd_addr(mem_rd_addr), .mem_wr_addr(mem_wr_addr)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rdata(input logic [1:0] c, input logic hw);
    logic [31:0] t;
    t = (m_dual && !m_sel) ? m_wr : m_rd;
    if (c == 2'b00) return hw ? 16'h0 : {14'b0, m_sel, m_dual};
    if (c == 2'b10) return hw ? t[31:16] : t[15:0];
    return 16'h0;
  endfunction

  task automatic acc(input logic [1:0] c, input logic rnw, input logic hw,
                     input logic [15:0] d, input string tag);
    @(negedge clk);
    host_valid = 1'b1; host_ctl = c; host_rnw = rnw; host_hw = hw; host_wdata = d;
    #1;
    if (rnw) check(tag, "host_rdata", {16'h0, host_rdata}, {16'h0, exp_rdata(c, hw)});
    if (c == 2'b01 || c == 2'b11) begin
      check(tag, "mem_rd_addr during access", mem_rd_addr, m_rd);
      check(tag, "mem_wr_addr during access", mem_wr_addr, m_wr);
    end
    @(posedge clk);
    #1;
    host_valid = 1'b0;
    case (c)
      2'b00: if (!rnw && !hw) begin m_dual = d[0]; m_sel = d[1]; end
      2'b10: if (!rnw) begin
        if (!hw) m_stage = d;
        else begin
          if (!m_dual || m_sel)  m_rd = {d, m_stage};
          if (!m_dual || !m_sel) m_wr = {d, m_stage};
        end
      end
      2'b01: if (hw) begin
        if (rnw || !m_dual)  m_rd = m_rd + 32'd4;
        if (!rnw || !m_dual) m_wr = m_wr + 32'd4;
      end
      default: ;
    endcase
    check(tag, "mem_rd_addr after", mem_rd_addr, m_rd);
    check(tag, "mem_wr_addr after", mem_wr_addr, m_wr);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1", "mem_rd_addr", mem_rd_addr, 32'h0);
    check("R1", "mem_wr_addr", mem_wr_addr, 32'h0);
    acc(2'b00, 1'b1, 1'b0, 16'h0, "R1");

    for (int cfg = 0; cfg < 4; cfg++) begin
      string adr_tag, ard_tag, awr_tag;
      acc(2'b00, 1'b0, 1'b0, 16'(cfg), "R2");
      acc(2'b00, 1'b0, 1'b1, 16'hFFFF, "R2");
      acc(2'b00, 1'b1, 1'b0, 16'h0, "R2");
      acc(2'b00, 1'b1, 1'b1, 16'h0, "R2");
      adr_tag = !m_dual ? "R4" : (m_sel ? "R5" : "R6");
      ard_tag = m_dual ? "R7" : "R10";
      awr_tag = m_dual ? "R8" : "R10";
      for (int k = 0; k < 6; k++) begin
        logic [31:0] v;
        v = (k == 5) ? 32'hFFFF_FFF8 : (32'h1357_9BDC * (k + 1)) ^ (32'h0000_1000 << cfg);
        v[1:0] = 2'b00;
        acc(2'b10, 1'b0, 1'b0, v[15:0], "R3");
        acc(2'b10, 1'b0, 1'b1, v[31:16], adr_tag);
        acc(2'b10, 1'b1, 1'b0, 16'h0, adr_tag);
        acc(2'b10, 1'b1, 1'b1, 16'h0, adr_tag);
        acc(2'b01, 1'b1, 1'b0, 16'h0, "R12");
        acc(2'b01, 1'b1, 1'b1, 16'h0, ard_tag);
        acc(2'b01, 1'b0, 1'b0, 16'h1111, "R12");
        acc(2'b01, 1'b0, 1'b1, 16'h2222, awr_tag);
        acc(2'b01, 1'b1, 1'b1, 16'h0, ard_tag);
        acc(2'b11, 1'b1, 1'b0, 16'h0, "R9");
        acc(2'b11, 1'b1, 1'b1, 16'h0, "R9");
        acc(2'b11, 1'b0, 1'b1, 16'h3333, "R9");
        acc(2'b10, 1'b1, 1'b1, 16'h0, adr_tag);
      end
      // R11: transfer-engine addresses follow their own pointer whatever select holds
      check("R11", "mem_rd_addr", mem_rd_addr, m_rd);
      check("R11", "mem_wr_addr", mem_wr_addr, m_wr);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule